// File: doc/BRIEF.md
# Cache Event Counter Bank

This block counts traffic events seen by one tile of a last-level cache. Four identical 32-bit counters sit behind a simple 32-bit register bus. Each counter has two registers, a control word and a data word. Software picks the event a counter follows by writing a 5-bit event code into the control word. Writing zero to the control word halts the counter.

The cache tile raises single-cycle strobes, one for each kind of request or hit it handles. Every counter whose code matches a strobe adds one on that clock edge. Software reads the counts through the bus and clears or preloads them through the data word. There is no overflow interrupt, so software must sample each counter before its 32-bit range wraps.

Reads return data one cycle after the request, flagged by a valid pulse.

Top module: `ecb_bank`

## Requirements
- R1: After reset every counter holds 0, every event code is 0, `reg_rdata` is 0 and `reg_rvalid` is low.
- R2: The control word of counter n is at byte address 0xA8 + 8*n. It keeps only bits [7:3] of a write as the event code. A read returns the code in bits [7:3] with all other bits zero.
- R3: Supported codes map to strobe lanes of `ev_strobe` as follows:
  - 0x0D read request → bit 0
  - 0x0E writeback request → bit 1
  - 0x0F invalidate-and-write request → bit 2
  - 0x10 invalidate request → bit 3
  - 0x13 evict request → bit 4
  - 0x14 invalidate-and-write hit → bit 5
  - 0x15 invalidate hit → bit 6
  - 0x17 read hit → bit 7

  A counter adds 1 on each rising edge where its mapped lane is high. It ignores all other lanes.
- R4: A counter whose code is not in the R3 list, including 0, keeps its value whatever the strobes do.
- R5: Writing 0 to a control word stops that counter and leaves its count unchanged.
- R6: The data word of counter n is at byte address 0xAC + 8*n. A write loads the written value, so writing 0 clears the count. A data write wins over a strobe in the same cycle.
- R7: A counter at 0xFFFFFFFF that takes one more event becomes 0.
- R8: A read request is answered on the next cycle by `reg_rvalid` high, with `reg_rdata` holding the register's value from before any same-cycle write. An address that maps to no register reads as 0.
- R9: Counters are independent. Two counters holding the same code both count the same strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read response, one cycle after `reg_ren` |
| ev_strobe | input | 8 | Event strobes, lane order as in R3 |

## Verification
A strobe that is high across a rising edge shows up in the count at that edge. A read issued at the next edge returns it, and `reg_rvalid` with the data arrives exactly one cycle after `reg_ren`. The bench changes inputs on falling edges, so each strobe or write is seen by exactly one known rising edge. A read task queues the value expected from the requirements. A monitor pops that value at the falling edge after the answering rising edge and flags any response that arrives with nothing queued. Same-cycle cases, such as a data write against a live strobe, are driven in one falling-edge slot so the priority decision happens at a single edge.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    localparam int DATA_W = 32;
    localparam int CODE_W = 5;
    localparam int NUM_EV = 8;
    localparam int LANE_W = $clog2(NUM_EV);
    localparam int ADDR_W = 8;
    localparam int CODE_LSB = 3;

    typedef enum logic [CODE_W-1:0] {
        EVC_RD_REQ  = 5'h0D,
        EVC_WB_REQ  = 5'h0E,
        EVC_IW_REQ  = 5'h0F,
        EVC_INV_REQ = 5'h10,
        EVC_EVICT   = 5'h13,
        EVC_IW_HIT  = 5'h14,
        EVC_INV_HIT = 5'h15,
        EVC_RD_HIT  = 5'h17
    } ev_code_e;

    typedef struct packed {
        logic              hit;
        logic [LANE_W-1:0] lane;
    } lane_sel_t;

    typedef struct packed {
        logic              wen;
        logic              ren;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic lane_sel_t code_to_lane(input logic [CODE_W-1:0] code);
        lane_sel_t s;
        s.hit  = 1'b1;
        s.lane = '0;
        case (code)
            EVC_RD_REQ:  s.lane = 3'd0;
            EVC_WB_REQ:  s.lane = 3'd1;
            EVC_IW_REQ:  s.lane = 3'd2;
            EVC_INV_REQ: s.lane = 3'd3;
            EVC_EVICT:   s.lane = 3'd4;
            EVC_IW_HIT:  s.lane = 3'd5;
            EVC_INV_HIT: s.lane = 3'd6;
            EVC_RD_HIT:  s.lane = 3'd7;
            default:     s.hit  = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ecb_regdec.sv
module ecb_regdec
    import ecb_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter int CTRL_BASE = 'hA8,
    parameter int STRIDE    = 8,
    parameter int DATA_OFS  = 4,
    localparam int IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  bus_req_t           req,
    output logic [NUM_CNT-1:0] ctrl_we,
    output logic [NUM_CNT-1:0] data_we,
    output logic               rd_hit,
    output logic               rd_is_data,
    output logic [IDX_W-1:0]   rd_idx
);

    logic [NUM_CNT-1:0] ctrl_match;
    logic [NUM_CNT-1:0] data_match;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_match
        localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_BASE + STRIDE * i);
        localparam logic [ADDR_W-1:0] DA = ADDR_W'(CTRL_BASE + STRIDE * i + DATA_OFS);
        assign ctrl_match[i] = (req.addr == CA);
        assign data_match[i] = (req.addr == DA);
        assign ctrl_we[i]    = req.wen && ctrl_match[i];
        assign data_we[i]    = req.wen && data_match[i];
    end

    always_comb begin
        rd_hit     = 1'b0;
        rd_is_data = 1'b0;
        rd_idx     = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (ctrl_match[i] || data_match[i]) begin
                rd_hit     = 1'b1;
                rd_is_data = data_match[i];
                rd_idx     = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ecb_counter.sv
module ecb_counter
    import ecb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_EV-1:0] ev_strobe,
    output logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] count
);

    lane_sel_t sel;
    logic      bump;

    assign sel  = code_to_lane(code);
    assign bump = sel.hit && ev_strobe[sel.lane];

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            count <= '0;
        end else begin
            if (ctrl_we) begin
                code <= wdata[CODE_LSB +: CODE_W];
            end
            if (data_we) begin
                count <= wdata;
            end else if (bump) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecb_bank.sv
module ecb_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter int CTRL_BASE = 'hA8,
    parameter int STRIDE    = 8,
    localparam int IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic              reg_ren,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic [NUM_EV-1:0] ev_strobe
);

    bus_req_t                      req;
    logic [NUM_CNT-1:0]            ctrl_we;
    logic [NUM_CNT-1:0]            data_we;
    logic                          rd_hit;
    logic                          rd_is_data;
    logic [IDX_W-1:0]              rd_idx;
    logic [NUM_CNT-1:0][DATA_W-1:0] cnt_vec;
    logic [NUM_CNT-1:0][CODE_W-1:0] code_vec;
    logic [DATA_W-1:0]             rd_word;

    assign req = '{wen: reg_wen, ren: reg_ren, addr: reg_addr, wdata: reg_wdata};

    ecb_regdec #(
        .NUM_CNT  (NUM_CNT),
        .CTRL_BASE(CTRL_BASE),
        .STRIDE   (STRIDE),
        .DATA_OFS (STRIDE / 2)
    ) u_dec (
        .req       (req),
        .ctrl_we   (ctrl_we),
        .data_we   (data_we),
        .rd_hit    (rd_hit),
        .rd_is_data(rd_is_data),
        .rd_idx    (rd_idx)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        ecb_counter u_cnt (
            .clk      (clk),
            .rst      (rst),
            .ctrl_we  (ctrl_we[i]),
            .data_we  (data_we[i]),
            .wdata    (reg_wdata),
            .ev_strobe(ev_strobe),
            .code     (code_vec[i]),
            .count    (cnt_vec[i])
        );
    end

    always_comb begin
        rd_word = '0;
        if (rd_hit) begin
            if (rd_is_data) begin
                rd_word = cnt_vec[rd_idx];
            end else begin
                rd_word[CODE_LSB +: CODE_W] = code_vec[rd_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_ren;
            if (reg_ren) begin
                reg_rdata <= rd_word;
            end
        end
    end

endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk
    import ecb_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           reg_ren,
    input logic                           reg_rvalid,
    input logic [DATA_W-1:0]              reg_wdata,
    input logic [NUM_CNT-1:0]             data_we,
    input logic [NUM_CNT-1:0][DATA_W-1:0] cnt_vec,
    input logic [NUM_CNT-1:0][CODE_W-1:0] code_vec
);

    // R8: one response per request, exactly one cycle later
    p_rvalid_lat_r8: assert property (@(posedge clk) disable iff (rst)
        reg_ren |=> reg_rvalid);
    p_rvalid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !reg_ren |=> !reg_rvalid);

    // R1: reset clears every count
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt_vec == '0 && code_vec == '0));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        lane_sel_t s;
        assign s = code_to_lane(code_vec[i]);

        // R6: data write loads the written word, over any strobe
        p_load_r6: assert property (@(posedge clk) disable iff (rst)
            data_we[i] |=> cnt_vec[i] == $past(reg_wdata));

        // R3 / R7: without a load the count moves by at most one, modulo 2^32
        p_step_r3: assert property (@(posedge clk) disable iff (rst)
            !data_we[i] |=> (cnt_vec[i] == $past(cnt_vec[i]) ||
                             cnt_vec[i] == $past(cnt_vec[i]) + 32'd1));

        // R4: unsupported code keeps the counter frozen
        p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
            (!s.hit && !data_we[i]) |=> $stable(cnt_vec[i]));
    end

endmodule

bind ecb_bank ecb_bank_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_ren   (reg_ren),
    .reg_rvalid(reg_rvalid),
    .reg_wdata (reg_wdata),
    .data_we   (data_we),
    .cnt_vec   (cnt_vec),
    .code_vec  (code_vec)
);

// File: tb/test_ecb_bank.sv
module test_ecb_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic        reg_ren = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [7:0]  ev_strobe = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    ecb_bank i_ecb_bank (
        .clk       (clk),
        .rst       (rst),
        .reg_wen   (reg_wen),
        .reg_ren   (reg_ren),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_rvalid(reg_rvalid),
        .ev_strobe (ev_strobe)
    );

    function automatic logic [7:0] ctrl_a(input int n);
        return 8'(8'hA8 + 8 * n);
    endfunction
    function automatic logic [7:0] data_a(input int n);
        return 8'(8'hAC + 8 * n);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_ren = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_ren = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m, input int n);
        ev_strobe = m;
        repeat (n) @(negedge clk);
        ev_strobe = '0;
    endtask

    // monitor: scoreboard pop and compare
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && reg_rvalid) begin
                if (exp_q.size() == 0) begin
                    check("R8 response without request", 32'd1, 32'd0);
                end else begin
                    check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdata after reset", reg_rdata, 32'd0);
        check("R1 rvalid after reset", {31'd0, reg_rvalid}, 32'd0);
        for (int n = 0; n < 4; n++) begin
            rd(ctrl_a(n), 32'd0, "R1 ctrl reset");
            rd(data_a(n), 32'd0, "R1 data reset");
        end

        // R2: code kept in [7:3], other bits dropped
        wr(ctrl_a(0), (32'h0D << 3) | 32'hFFFF_FF07);
        wr(ctrl_a(1), 32'h17 << 3);
        wr(ctrl_a(2), 32'h13 << 3);
        wr(ctrl_a(3), 32'h11 << 3);
        rd(ctrl_a(0), 32'h68, "R2 ctrl0 readback");
        rd(ctrl_a(1), 32'hB8, "R2 ctrl1 readback");
        rd(ctrl_a(3), 32'h88, "R2 ctrl3 readback");

        // R3 / R4
        pulse(8'hFF, 5);
        rd(data_a(0), 32'd5, "R3 read-request count");
        rd(data_a(1), 32'd5, "R3 read-hit count");
        rd(data_a(2), 32'd5, "R3 evict count");
        rd(data_a(3), 32'd0, "R4 unsupported code frozen");
        pulse(8'h01, 3);
        rd(data_a(0), 32'd8, "R3 lane 0 only");
        rd(data_a(1), 32'd5, "R3 other lanes ignored");

        // R5
        wr(ctrl_a(1), 32'd0);
        pulse(8'h80, 4);
        rd(data_a(1), 32'd5, "R5 stopped counter keeps value");
        rd(ctrl_a(1), 32'd0, "R5 ctrl reads zero");

        // R6
        wr(data_a(0), 32'd0);
        rd(data_a(0), 32'd0, "R6 clear");
        ev_strobe = 8'h01;
        wr(data_a(0), 32'd100);
        ev_strobe = 8'h00;
        rd(data_a(0), 32'd100, "R6 write beats strobe");

        // R7
        wr(data_a(2), 32'hFFFF_FFFE);
        pulse(8'h10, 3);
        rd(data_a(2), 32'd1, "R7 wrap");

        // R8: unmapped and same-cycle read/write
        rd(8'hA4, 32'd0, "R8 unmapped below");
        rd(8'hC8, 32'd0, "R8 unmapped above");
        reg_wen = 1'b1; reg_ren = 1'b1; reg_addr = data_a(2); reg_wdata = 32'd77;
        exp_q.push_back(32'd1); tag_q.push_back("R8 read returns old value");
        @(negedge clk);
        reg_wen = 1'b0; reg_ren = 1'b0;
        rd(data_a(2), 32'd77, "R8 write landed");

        // R9
        wr(ctrl_a(3), 32'h0D << 3);
        wr(data_a(0), 32'd0);
        wr(data_a(3), 32'd0);
        pulse(8'h01, 2);
        rd(data_a(0), 32'd2, "R9 counter0 shared code");
        rd(data_a(3), 32'd2, "R9 counter3 shared code");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R8 missing responses", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule